// File: doc/BRIEF.md
# Layer Address Expander

This block sits between the parity-check description store and the permutation and processor array of a layered decoder. The check matrix has been reordered so that nine consecutive layers share one stored block list. For each nonzero block of a layer, the store holds a pair: the address of the a-posteriori block it touches, and the cyclic shift that the barrel shifter applies. Only the first layer of each group of nine is kept in storage. The block loads that layer's pairs and then produces the pairs for all nine layers, one pair per clock.

A load starts with a strobe that carries the number of nonzero blocks in the layer, known as the row weight. That many store words follow, one per valid cycle. After that, each run request streams the current layer's pairs in index order. Each pair is replaced in place by the pair for the next layer as it leaves the block. A pair's successor is the next address, except when the address sits in the last slot of its nine-block group. In that case the address falls back to the start of the group and the shift drops by one. A layer counter tracks the position within the group. When the ninth layer has gone out, the block raises a flag to ask for the next load.

Top module: `layer_addr_gen`

## Requirements
- R1: After reset, outValid is 0, needLoad is 1 and layerIdx is 0.
- R2: A loadStart while no layer is streaming latches the row weight, clears needLoad and sets layerIdx to 0. A weight of 0 is treated as 1, and a weight above 22 is treated as 22. The next weight romValid cycles write entries 0, 1, ... in order, taking romAddr and romShift as the pair.
- R3: A runLayer that is accepted at a clock edge starts a stream after that edge. The stream holds outValid high for exactly weight consecutive cycles, with outIdx counting from 0, and outLast high only on the final entry. outValid then falls.
- R4: The first layer after a load outputs the loaded pairs unchanged.
- R5: If a pair's address modulo 9 is not 8, its pair in the next layer is (address + 1, same shift).
- R6: If a pair's address modulo 9 is 8, its pair in the next layer is (address − 8, shift − 1).
- R7: A shift of 0 that is decremented under R6 becomes 39.
- R8: After the final entry of each layer, layerIdx advances by one. After the ninth layer (layerIdx 8), layerIdx returns to 0 and needLoad rises.
- R9: runLayer is ignored while a layer is streaming, while needLoad is 1, and while the load is still waiting for words.
- R10: Every output shift lies in 0 to 39.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| loadStart | input | 1 | Starts loading a new group |
| loadWeight | input | 5 | Row weight for the new group |
| romValid | input | 1 | A store word is present |
| romAddr | input | 11 | Block address of the store word |
| romShift | input | 6 | Cyclic shift of the store word |
| runLayer | input | 1 | Request to stream the current layer |
| outValid | output | 1 | Output pair valid |
| outIdx | output | 5 | Entry index of the output pair |
| outAddr | output | 11 | Block address for this layer |
| outShift | output | 6 | Cyclic shift for this layer |
| outLast | output | 1 | Final entry of the layer |
| layerIdx | output | 4 | Layer position within the group |
| needLoad | output | 1 | Group used up, reload required |

## Verification
The update rule rewrites each entry in place, so a wrong successor does not show up until the same entry is read again one layer later. An error then keeps propagating through every remaining layer of the group. The bench compares each pair of all nine layers with a closed-form value computed from the seed. This catches a wrong successor within one layer and shows which entry and layer went wrong. A bad stream length, a missed index step or a slipped layer counter shows at the port in the cycle it happens, through outValid, outIdx, outLast, layerIdx and needLoad.

// File: rtl/layer_addr_gen_pkg.sv
package layer_addr_gen_pkg;

  typedef struct packed {
    logic wrEn;
    logic stepEn;
  } ctlStrobe_t;

endpackage

// File: rtl/layer_addr_gen_ctrl.sv
module layer_addr_gen_ctrl
  import layer_addr_gen_pkg::*;
#(
  parameter int MAX_ENTRIES  = 22,
  parameter int GROUP_LAYERS = 9,
  localparam int IDX_W   = $clog2(MAX_ENTRIES),
  localparam int CNT_W   = $clog2(MAX_ENTRIES + 1),
  localparam int LAYER_W = $clog2(GROUP_LAYERS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               loadStart,
  input  logic [CNT_W-1:0]   loadWeight,
  input  logic               romValid,
  input  logic               runLayer,
  output ctlStrobe_t         strobe,
  output logic [IDX_W-1:0]   wrIdx,
  output logic [IDX_W-1:0]   rdIdx,
  output logic               busy,
  output logic               lastEntry,
  output logic [CNT_W-1:0]   curWeight,
  output logic [LAYER_W-1:0] layerCnt,
  output logic               needLoad
);

  logic [CNT_W-1:0] wrPtr;
  logic [CNT_W-1:0] effWeight;
  logic [CNT_W-1:0] lastIdx;
  logic             loadDone;
  logic             loadAccept;
  logic             runAccept;
  logic             groupEnd;

  always_comb begin
    if (loadWeight == '0)
      effWeight = CNT_W'(1);
    else if (loadWeight > CNT_W'(MAX_ENTRIES))
      effWeight = CNT_W'(MAX_ENTRIES);
    else
      effWeight = loadWeight;
  end

  assign lastIdx    = curWeight - CNT_W'(1);
  assign loadDone   = (wrPtr >= curWeight);
  assign loadAccept = loadStart & ~busy;
  assign runAccept  = runLayer & ~busy & ~needLoad & loadDone & ~loadStart;
  assign lastEntry  = busy & (CNT_W'(rdIdx) == lastIdx);
  assign groupEnd   = (layerCnt == LAYER_W'(GROUP_LAYERS - 1));

  assign strobe.wrEn   = romValid & ~busy & ~loadStart & ~loadDone;
  assign strobe.stepEn = busy;
  assign wrIdx         = wrPtr[IDX_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curWeight <= CNT_W'(1);
      wrPtr     <= CNT_W'(1);
      rdIdx     <= '0;
      busy      <= 1'b0;
      layerCnt  <= '0;
      needLoad  <= 1'b1;
    end else if (loadAccept) begin
      curWeight <= effWeight;
      wrPtr     <= '0;
      layerCnt  <= '0;
      needLoad  <= 1'b0;
    end else begin
      if (strobe.wrEn)
        wrPtr <= wrPtr + CNT_W'(1);
      if (runAccept) begin
        busy  <= 1'b1;
        rdIdx <= '0;
      end else if (busy) begin
        if (lastEntry) begin
          busy  <= 1'b0;
          rdIdx <= '0;
          if (groupEnd) begin
            layerCnt <= '0;
            needLoad <= 1'b1;
          end else begin
            layerCnt <= layerCnt + LAYER_W'(1);
          end
        end else begin
          rdIdx <= rdIdx + IDX_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/layer_addr_gen_dp.sv
module layer_addr_gen_dp
  import layer_addr_gen_pkg::*;
#(
  parameter int MAX_ENTRIES  = 22,
  parameter int GROUP_LAYERS = 9,
  parameter int LANES        = 40,
  parameter int ADDR_W       = 11,
  localparam int IDX_W   = $clog2(MAX_ENTRIES),
  localparam int SHIFT_W = $clog2(LANES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobe_t         strobe,
  input  logic [IDX_W-1:0]   wrIdx,
  input  logic [IDX_W-1:0]   rdIdx,
  input  logic [ADDR_W-1:0]  romAddr,
  input  logic [SHIFT_W-1:0] romShift,
  output logic [ADDR_W-1:0]  selAddr,
  output logic [SHIFT_W-1:0] selShift
);

  logic [ADDR_W-1:0]  addrQ  [MAX_ENTRIES];
  logic [SHIFT_W-1:0] shiftQ [MAX_ENTRIES];
  logic [ADDR_W-1:0]  slotPos;
  logic               slotWrap;
  logic [ADDR_W-1:0]  nxtAddr;
  logic [SHIFT_W-1:0] nxtShift;

  assign selAddr  = addrQ[rdIdx];
  assign selShift = shiftQ[rdIdx];

  always_comb begin
    slotPos  = selAddr % ADDR_W'(GROUP_LAYERS);
    slotWrap = (slotPos == ADDR_W'(GROUP_LAYERS - 1));
    if (slotWrap) begin
      nxtAddr = selAddr - ADDR_W'(GROUP_LAYERS - 1);
      if (selShift == '0)
        nxtShift = SHIFT_W'(LANES - 1);
      else
        nxtShift = selShift - SHIFT_W'(1);
    end else begin
      nxtAddr  = selAddr + ADDR_W'(1);
      nxtShift = selShift;
    end
  end

  for (genvar e = 0; e < MAX_ENTRIES; e++) begin : gEntry
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        addrQ[e]  <= '0;
        shiftQ[e] <= '0;
      end else if (strobe.wrEn && wrIdx == IDX_W'(e)) begin
        addrQ[e]  <= romAddr;
        shiftQ[e] <= romShift;
      end else if (strobe.stepEn && rdIdx == IDX_W'(e)) begin
        addrQ[e]  <= nxtAddr;
        shiftQ[e] <= nxtShift;
      end
    end
  end

endmodule

// File: rtl/layer_addr_gen.sv
module layer_addr_gen
  import layer_addr_gen_pkg::*;
#(
  parameter int MAX_ENTRIES  = 22,
  parameter int GROUP_LAYERS = 9,
  parameter int LANES        = 40,
  parameter int ADDR_W       = 11,
  localparam int IDX_W   = $clog2(MAX_ENTRIES),
  localparam int CNT_W   = $clog2(MAX_ENTRIES + 1),
  localparam int SHIFT_W = $clog2(LANES),
  localparam int LAYER_W = $clog2(GROUP_LAYERS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               loadStart,
  input  logic [CNT_W-1:0]   loadWeight,
  input  logic               romValid,
  input  logic [ADDR_W-1:0]  romAddr,
  input  logic [SHIFT_W-1:0] romShift,
  input  logic               runLayer,
  output logic               outValid,
  output logic [IDX_W-1:0]   outIdx,
  output logic [ADDR_W-1:0]  outAddr,
  output logic [SHIFT_W-1:0] outShift,
  output logic               outLast,
  output logic [LAYER_W-1:0] layerIdx,
  output logic               needLoad
);

  ctlStrobe_t       strobe;
  logic [IDX_W-1:0] wrIdx;
  logic [IDX_W-1:0] rdIdx;
  logic             busy;
  logic             lastEntry;
  logic [CNT_W-1:0] curWeight;

  layer_addr_gen_ctrl #(
    .MAX_ENTRIES (MAX_ENTRIES),
    .GROUP_LAYERS(GROUP_LAYERS)
  ) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .loadStart (loadStart),
    .loadWeight(loadWeight),
    .romValid  (romValid),
    .runLayer  (runLayer),
    .strobe    (strobe),
    .wrIdx     (wrIdx),
    .rdIdx     (rdIdx),
    .busy      (busy),
    .lastEntry (lastEntry),
    .curWeight (curWeight),
    .layerCnt  (layerIdx),
    .needLoad  (needLoad)
  );

  layer_addr_gen_dp #(
    .MAX_ENTRIES (MAX_ENTRIES),
    .GROUP_LAYERS(GROUP_LAYERS),
    .LANES       (LANES),
    .ADDR_W      (ADDR_W)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .wrIdx   (wrIdx),
    .rdIdx   (rdIdx),
    .romAddr (romAddr),
    .romShift(romShift),
    .selAddr (outAddr),
    .selShift(outShift)
  );

  assign outValid = busy;
  assign outIdx   = rdIdx;
  assign outLast  = lastEntry;

endmodule

// File: rtl/layer_addr_gen_chk.sv
module layer_addr_gen_chk #(
  parameter int MAX_ENTRIES  = 22,
  parameter int GROUP_LAYERS = 9,
  parameter int LANES        = 40,
  localparam int IDX_W   = $clog2(MAX_ENTRIES),
  localparam int CNT_W   = $clog2(MAX_ENTRIES + 1),
  localparam int SHIFT_W = $clog2(LANES),
  localparam int LAYER_W = $clog2(GROUP_LAYERS)
) (
  input logic               clk,
  input logic               rstN,
  input logic               outValid,
  input logic [IDX_W-1:0]   outIdx,
  input logic [SHIFT_W-1:0] outShift,
  input logic               outLast,
  input logic [LAYER_W-1:0] layerIdx,
  input logic               needLoad,
  input logic [CNT_W-1:0]   curWeight
);

  AST_IDX_BELOW_WEIGHT: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (CNT_W'(outIdx) < curWeight)); // R3

  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outLast) |=> (outValid && outIdx == $past(outIdx) + IDX_W'(1))); // R3

  AST_FIRST_IDX: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |-> (outIdx == '0)); // R3

  AST_SHIFT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (int'(outShift) < LANES)); // R10

  AST_LAYER_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    int'(layerIdx) < GROUP_LAYERS); // R8

  AST_NO_RUN_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    needLoad |-> !outValid); // R9

  AST_GROUP_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (outLast && int'(layerIdx) == GROUP_LAYERS - 1) |=> (needLoad && layerIdx == '0)); // R8

endmodule

bind layer_addr_gen layer_addr_gen_chk #(
  .MAX_ENTRIES (MAX_ENTRIES),
  .GROUP_LAYERS(GROUP_LAYERS),
  .LANES       (LANES)
) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .outValid (outValid),
  .outIdx   (outIdx),
  .outShift (outShift),
  .outLast  (outLast),
  .layerIdx (layerIdx),
  .needLoad (needLoad),
  .curWeight(curWeight)
);

// File: tb/layer_addr_gen_tb.sv
module layer_addr_gen_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int MAXE  = 22;
  localparam int GRP   = 9;
  localparam int LANES = 40;
  localparam int ADDRS = 1620;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        loadStart = 1'b0;
  logic [4:0]  loadWeight = '0;
  logic        romValid = 1'b0;
  logic [10:0] romAddr = '0;
  logic [5:0]  romShift = '0;
  logic        runLayer = 1'b0;
  logic        outValid;
  logic [4:0]  outIdx;
  logic [10:0] outAddr;
  logic [5:0]  outShift;
  logic        outLast;
  logic [3:0]  layerIdx;
  logic        needLoad;

  int nChecks = 0;
  int nFail = 0;
  bit done = 0;
  int seedA [MAXE];
  int seedS [MAXE];
  int effW;

  always #(CLK_PERIOD/2) clk = ~clk;

  layer_addr_gen dut_i (
    .clk(clk), .rstN(rstN), .loadStart(loadStart), .loadWeight(loadWeight),
    .romValid(romValid), .romAddr(romAddr), .romShift(romShift),
    .runLayer(runLayer), .outValid(outValid), .outIdx(outIdx),
    .outAddr(outAddr), .outShift(outShift), .outLast(outLast),
    .layerIdx(layerIdx), .needLoad(needLoad)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic loadGroup(input int w, input bit pokeEarly);
    effW = (w == 0) ? 1 : ((w > MAXE) ? MAXE : w);
    loadStart = 1'b1;
    loadWeight = 5'(w);
    @(negedge clk);
    loadStart = 1'b0;
    chk(needLoad == 1'b0, "R2", "needLoad after load", int'(needLoad), 0);
    chk(layerIdx == 4'd0, "R2", "layerIdx after load", int'(layerIdx), 0);
    for (int e = 0; e < effW; e++) begin
      romValid = 1'b1;
      romAddr = 11'(seedA[e]);
      romShift = 6'(seedS[e]);
      if (pokeEarly && e == 0) runLayer = 1'b1;
      @(negedge clk);
      runLayer = 1'b0;
      if (pokeEarly && e == 0 && effW > 1)
        chk(outValid == 1'b0, "R9", "run during load", int'(outValid), 0);
    end
    romValid = 1'b0;
  endtask

  task automatic runOne(input int lay, input bit poke);
    runLayer = 1'b1;
    @(negedge clk);
    runLayer = 1'b0;
    for (int i = 0; i < effW; i++) begin
      int r, t, ea, es;
      string tag;
      r = seedA[i] % GRP;
      t = r + lay;
      ea = seedA[i] - r + (t % GRP);
      es = (seedS[i] - t / GRP + LANES) % LANES;
      if (t >= GRP) tag = (seedS[i] == 0) ? "R7" : "R6";
      else tag = (lay == 0) ? "R4" : "R5";
      chk(outValid == 1'b1, "R3", "outValid in stream", int'(outValid), 1);
      chk(int'(outIdx) == i, "R3", "outIdx", int'(outIdx), i);
      chk(outLast == (i == effW - 1), "R3", "outLast", int'(outLast), int'(i == effW - 1));
      chk(int'(outAddr) == ea, tag, "outAddr", int'(outAddr), ea);
      chk(int'(outShift) == es, tag, "outShift", int'(outShift), es);
      chk(int'(outShift) < LANES, "R10", "shift range", int'(outShift), LANES - 1);
      if (poke && i == 0) runLayer = 1'b1;
      @(negedge clk);
      runLayer = 1'b0;
    end
    chk(outValid == 1'b0, poke ? "R9" : "R3", "outValid after stream", int'(outValid), 0);
    chk(int'(layerIdx) == (lay + 1) % GRP, "R8", "layerIdx", int'(layerIdx), (lay + 1) % GRP);
    chk(needLoad == (lay == GRP - 1), "R8", "needLoad", int'(needLoad), int'(lay == GRP - 1));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(outValid == 1'b0, "R1", "reset outValid", int'(outValid), 0);
    chk(needLoad == 1'b1, "R1", "reset needLoad", int'(needLoad), 1);
    chk(layerIdx == 4'd0, "R1", "reset layerIdx", int'(layerIdx), 0);
    rstN = 1'b1;
    @(negedge clk);
    runLayer = 1'b1;
    @(negedge clk);
    runLayer = 1'b0;
    chk(outValid == 1'b0, "R9", "run before any load", int'(outValid), 0);
    for (int g = 0; g < 40; g++) begin
      int w;
      if (g == 0) w = 1;
      else if (g == 1) w = 22;
      else if (g == 2) w = 0;
      else if (g == 3) w = 31;
      else w = 1 + int'($urandom % MAXE);
      for (int e = 0; e < MAXE; e++) begin
        seedA[e] = int'($urandom % ADDRS);
        seedS[e] = int'($urandom % LANES);
        if ((e + g) % 3 == 0) seedS[e] = 0;
        if ((e + g) % 4 == 1) seedA[e] = seedA[e] - seedA[e] % GRP + GRP - 1;
      end
      loadGroup(w, g % 2 == 1);
      for (int lay = 0; lay < GRP; lay++) runOne(lay, lay == 3);
      runLayer = 1'b1;
      @(negedge clk);
      runLayer = 1'b0;
      @(negedge clk);
      chk(outValid == 1'b0, "R9", "run while needLoad", int'(outValid), 0);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

endmodule